// File: doc/BRIEF.md
# Cache-Aligned Burst Size Sequencer

This block turns one transfer request into a sequence of bus transactions. Each transaction's length is chosen so that the transfer reaches a cache-line boundary quickly and then stays on it. A request carries a start byte address, a byte count and the programmed cache line size in dwords. The block then hands out one transaction at a time. Each transaction has a byte address, a length in dwords and a four-lane byte enable. A downstream bus engine takes each transaction over a valid/ready handshake.

Below a 16-byte boundary the block moves one dword at a time. From a 16-byte boundary onward it picks the largest power-of-two burst that the current address is aligned to, never more than a cache line. Once it reaches a line boundary, every later burst is a full line, until the byte count runs short. For a memory-to-memory move, the request also carries the address on the other side. If the two addresses sit at different byte offsets inside a line, alignment is switched off and the whole move goes out as single dwords.

Top module: `cache_burst_seq`

## Requirements
- R1: While the current address is not a multiple of 16 bytes, each transaction is a single dword (length 1).
- R2: A single transaction at a non-dword-aligned address carries only the bytes up to the next dword boundary. Byte enable bit i stands for byte lane i, meaning address offset i within the dword. A start at offset 1 with enough data gives enable 4'b1110.
- R3: At a 16-byte boundary, the length is the largest power of two from 4 up to the line size whose byte size (length times 4) divides the current address.
- R4: At an address that is a multiple of the line size in bytes, the length equals the line size, unless R5 trims it. With a 16-dword line and start 0x01, the lengths are 1,1,1,1 at 0x01..0x0C, then 4 at 0x10, 8 at 0x20, and 16 from 0x40.
- R5: A burst never moves more whole dwords than remain. Fewer than 4 whole dwords left go out as singles. A trailing partial dword is a single with enables on the low lanes, so 2 bytes give 4'b0011.
- R6: With the move flag set, if the start and peer addresses differ modulo the line size in bytes, every transaction is a single dword, with partial enables at both ends.
- R7: With the move flag set and equal offsets within a line, alignment proceeds as in R1 to R5.
- R8: A line size that is not a power of two from 4 to 64 disables alignment, and only single dwords are sent.
- R9: A transaction stays valid and unchanged until it is accepted. Each accepted transaction moves the address forward by its byte count.
- R10: req_ready is low from the accepting edge until the done pulse, and requests offered meanwhile are ignored. done is high for exactly one cycle, one cycle after the last transaction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request taken when both are high |
| req_addr | input | 32 | Start byte address |
| req_len | input | 16 | Byte count |
| req_line_dw | input | 8 | Cache line size in dwords |
| req_move | input | 1 | Request is one side of a memory move |
| req_peer_addr | input | 32 | Address of the other side of the move |
| txn_valid | output | 1 | Transaction available |
| txn_ready | input | 1 | Transaction accepted when both are high |
| txn_addr | output | 32 | Byte address of the transaction's first byte |
| txn_dwords | output | 7 | Length in dwords |
| txn_be | output | 4 | Byte lane enables (meaningful for singles; all set for bursts) |
| done | output | 1 | One-cycle pulse when the request is finished |

## Verification
The first transaction is visible on the outputs in the cycle after the clock edge that takes the request. Each later transaction appears in the cycle after the edge that accepts the one before. done rises one edge after the final acceptance. The bench drives at the falling edge and samples every output at the following falling edge, so each value is read a half cycle after the edge that produced it. While comparing transactions it holds txn_ready low on a fixed pattern, which also exercises the hold rule.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    localparam int ADDR_W   = 32;
    localparam int LEN_W    = 16;
    localparam int LINE_W   = 8;
    localparam int MIN_LOG  = 2;
    localparam int MAX_LOG  = 6;
    localparam int BURST_W  = MAX_LOG + 1;
    localparam int SHIFT_W  = $clog2(MAX_LOG + 1);
    localparam int LANES    = 4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } cur_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [BURST_W-1:0] dwords;
        logic [LANES-1:0]   be;
        logic [LEN_W-1:0]   bytes;
    } txn_t;

    // log2 of a legal line size, 0 when the size is not usable
    function automatic logic [SHIFT_W-1:0] line_shift(input logic [LINE_W-1:0] l);
        logic [SHIFT_W-1:0] r;
        r = '0;
        for (int k = MIN_LOG; k <= MAX_LOG; k++) begin
            if (l == LINE_W'(1 << k)) r = SHIFT_W'(k);
        end
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] low_mask(input int n);
        return (ADDR_W'(1) << n) - ADDR_W'(1);
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic [1:0] off,
                                                   input logic [2:0] cnt);
        logic [LANES:0] m;
        m = (5'd1 << cnt) - 5'd1;
        return m[LANES-1:0] << off;
    endfunction

endpackage

// File: rtl/cbs_move_check.sv
module cbs_move_check
    import cbs_pkg::*;
(
    input  logic [ADDR_W-1:0]  src_addr,
    input  logic [ADDR_W-1:0]  peer_addr,
    input  logic               move_en,
    input  logic [SHIFT_W-1:0] shift,
    output logic               bypass
);
    logic [ADDR_W-1:0] in_line;

    always_comb begin
        in_line = low_mask(int'(shift) + 2);
        bypass  = move_en && (shift != '0) &&
                  (((src_addr ^ peer_addr) & in_line) != '0);
    end
endmodule

// File: rtl/cbs_burst_pick.sv
module cbs_burst_pick
    import cbs_pkg::*;
(
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [LEN_W-1:0]   remain,
    input  logic               align_en,
    input  logic [SHIFT_W-1:0] shift,
    output txn_t               txn
);
    logic [1:0]         off;
    logic [2:0]         headroom;
    logic [2:0]         cnt;
    logic [LEN_W-3:0]   rem_dw;
    logic [SHIFT_W-1:0] p_shift;
    logic [BURST_W-1:0] p_dw;
    logic [BURST_W-1:0] dw;
    logic               go_single;

    always_comb begin
        off       = cur_addr[1:0];
        headroom  = 3'd4 - {1'b0, off};
        rem_dw    = remain[LEN_W-1:2];
        cnt       = (remain < LEN_W'(headroom)) ? remain[2:0] : headroom;
        go_single = !align_en || (cur_addr[3:0] != 4'd0) ||
                    (rem_dw < (LEN_W-2)'(4));

        p_shift = SHIFT_W'(MIN_LOG);
        for (int k = MIN_LOG; k <= MAX_LOG; k++) begin
            if (k <= int'(shift) && ((cur_addr & low_mask(k + 2)) == '0))
                p_shift = SHIFT_W'(k);
        end
        p_dw = BURST_W'(1) << p_shift;
        dw   = (rem_dw < (LEN_W-2)'(p_dw)) ? rem_dw[BURST_W-1:0] : p_dw;

        txn.addr = cur_addr;
        if (go_single) begin
            txn.dwords = BURST_W'(1);
            txn.be     = lane_mask(off, cnt);
            txn.bytes  = LEN_W'(cnt);
        end else begin
            txn.dwords = dw;
            txn.be     = '1;
            txn.bytes  = LEN_W'({dw, 2'b00});
        end
    end
endmodule

// File: rtl/cbs_cursor.sv
module cbs_cursor
    import cbs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [SHIFT_W-1:0] req_shift,
    input  logic               req_align_en,
    output logic               req_ready,
    input  logic               txn_ready,
    input  logic [LEN_W-1:0]   txn_bytes,
    output logic               txn_valid,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic [LEN_W-1:0]   remain,
    output logic               align_en,
    output logic [SHIFT_W-1:0] shift,
    output logic               done
);
    cur_state_e state;

    assign req_ready = (state == ST_IDLE);
    assign txn_valid = (state == ST_RUN) && (remain != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            remain   <= '0;
            align_en <= 1'b0;
            shift    <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_addr <= req_addr;
                        remain   <= req_len;
                        align_en <= req_align_en;
                        shift    <= req_shift;
                        state    <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (txn_valid && txn_ready) begin
                        cur_addr <= cur_addr + ADDR_W'(txn_bytes);
                        remain   <= remain - txn_bytes;
                    end else if (remain == '0) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> (txn_bytes <= remain) && (txn_bytes != '0)); // R5
    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (rst)
        txn_valid && !txn_ready |=> txn_valid && $stable(cur_addr) && $stable(remain)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready && !txn_valid); // R10
endmodule

// File: rtl/cache_burst_seq.sv
module cache_burst_seq
    import cbs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [LEN_W-1:0]    req_len,
    input  logic [LINE_W-1:0]   req_line_dw,
    input  logic                req_move,
    input  logic [ADDR_W-1:0]   req_peer_addr,
    output logic                txn_valid,
    input  logic                txn_ready,
    output logic [ADDR_W-1:0]   txn_addr,
    output logic [BURST_W-1:0]  txn_dwords,
    output logic [LANES-1:0]    txn_be,
    output logic                done
);
    logic [SHIFT_W-1:0] in_shift;
    logic               bypass;
    logic               in_align;
    logic [ADDR_W-1:0]  cur_addr;
    logic [LEN_W-1:0]   remain;
    logic               align_en;
    logic [SHIFT_W-1:0] shift;
    txn_t               pick;

    assign in_shift = line_shift(req_line_dw);
    assign in_align = (in_shift != '0) && !bypass;

    cbs_move_check u_move (
        .src_addr  (req_addr),
        .peer_addr (req_peer_addr),
        .move_en   (req_move),
        .shift     (in_shift),
        .bypass    (bypass)
    );

    cbs_cursor u_cursor (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .req_shift    (in_shift),
        .req_align_en (in_align),
        .req_ready    (req_ready),
        .txn_ready    (txn_ready),
        .txn_bytes    (pick.bytes),
        .txn_valid    (txn_valid),
        .cur_addr     (cur_addr),
        .remain       (remain),
        .align_en     (align_en),
        .shift        (shift),
        .done         (done)
    );

    cbs_burst_pick u_pick (
        .cur_addr (cur_addr),
        .remain   (remain),
        .align_en (align_en),
        .shift    (shift),
        .txn      (pick)
    );

    assign txn_addr   = pick.addr;
    assign txn_dwords = pick.dwords;
    assign txn_be     = pick.be;

    AST_SINGLE_OFF16: assert property (@(posedge clk) disable iff (rst)
        txn_valid && (txn_addr[3:0] != 4'd0) |-> txn_dwords == BURST_W'(1)); // R1
    AST_CAP_LINE: assert property (@(posedge clk) disable iff (rst)
        txn_valid && align_en |-> txn_dwords <= (BURST_W'(1) << shift)); // R3
    AST_BYPASS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        txn_valid && !align_en |-> txn_dwords == BURST_W'(1)); // R6
    AST_BURST_FULL_LANES: assert property (@(posedge clk) disable iff (rst)
        txn_valid && (txn_dwords != BURST_W'(1)) |-> txn_be == 4'hF); // R2
endmodule

// File: tb/cache_burst_seq_test.sv
`timescale 1ns/1ps
module cache_burst_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic [7:0]  req_line_dw = '0;
    logic        req_move = 1'b0;
    logic [31:0] req_peer_addr = '0;
    logic        txn_valid;
    logic        txn_ready = 1'b0;
    logic [31:0] txn_addr;
    logic [6:0]  txn_dwords;
    logic [3:0]  txn_be;
    logic        done;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    cache_burst_seq uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_line_dw(req_line_dw),
        .req_move(req_move), .req_peer_addr(req_peer_addr),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_addr(txn_addr), .txn_dwords(txn_dwords), .txn_be(txn_be),
        .done(done)
    );

    // request: addr, len, line, move, peer
    localparam int NS = 6;
    localparam logic [88:0] REQ [0:NS-1] = '{
        {32'h0000_0001, 16'd191, 8'd16, 1'b0, 32'h0},
        {32'h0000_021F, 16'd10,  8'd8,  1'b1, 32'h0000_042F},
        {32'h0000_020C, 16'd60,  8'd8,  1'b1, 32'h0000_050C},
        {32'h0000_0000, 16'd6,   8'd12, 1'b0, 32'h0},
        {32'h0000_0040, 16'd38,  8'd32, 1'b0, 32'h0},
        {32'h0000_0100, 16'd512, 8'd64, 1'b0, 32'h0}
    };
    localparam int NTX   [0:NS-1] = '{8, 4, 5, 2, 2, 2};
    localparam int FIRST [0:NS-1] = '{0, 8, 12, 17, 19, 21};
    // expected: addr, dwords, be
    localparam logic [43:0] EXP [0:22] = '{
        {32'h001, 8'd1,  4'hE}, {32'h004, 8'd1, 4'hF}, {32'h008, 8'd1, 4'hF},
        {32'h00C, 8'd1,  4'hF}, {32'h010, 8'd4, 4'hF}, {32'h020, 8'd8, 4'hF},
        {32'h040, 8'd16, 4'hF}, {32'h080, 8'd16, 4'hF},
        {32'h21F, 8'd1,  4'h8}, {32'h220, 8'd1, 4'hF}, {32'h224, 8'd1, 4'hF},
        {32'h228, 8'd1,  4'h1},
        {32'h20C, 8'd1,  4'hF}, {32'h210, 8'd4, 4'hF}, {32'h220, 8'd8, 4'hF},
        {32'h240, 8'd1,  4'hF}, {32'h244, 8'd1, 4'hF},
        {32'h000, 8'd1,  4'hF}, {32'h004, 8'd1, 4'h3},
        {32'h040, 8'd9,  4'hF}, {32'h064, 8'd1, 4'h3},
        {32'h100, 8'd64, 4'hF}, {32'h200, 8'd64, 4'hF}
    };

    function automatic string tag(int s);
        case (s)
            0: return "R1 R2 R3 R4";
            1: return "R6";
            2: return "R7";
            3: return "R8";
            4: return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic offer(input logic [88:0] r);
        @(negedge clk);
        {req_addr, req_len, req_line_dw, req_move, req_peer_addr} = r;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // drain transactions at negedges, stalling on a fixed pattern
    task automatic drain(input int s, input int first, input int ntx,
                         input bit compare);
        int  idx = 0;
        bit  seen = 0;
        bit  got_done = 0;
        int  done_cycles = 0;
        for (int cyc = 0; cyc < 600; cyc++) begin
            if (done) begin
                done_cycles++;
                got_done = 1;
            end
            if (got_done && !done) break;
            if (txn_valid) begin
                if (!seen && compare && idx < ntx) begin
                    check({txn_addr, 1'b0, txn_dwords, txn_be} == EXP[first+idx],
                          tag(s), $sformatf("scenario %0d txn %0d", s, idx),
                          {20'h0, txn_addr, 1'b0, txn_dwords, txn_be},
                          {20'h0, EXP[first+idx]});
                end
                seen = 1;
                txn_ready = ((cyc % 3) != 2);
                if (txn_ready) begin
                    idx++;
                    seen = 0;
                end
            end else begin
                txn_ready = 1'b0;
            end
            @(negedge clk);
        end
        txn_ready = 1'b0;
        check(idx == ntx, "R10", $sformatf("scenario %0d txn count", s), 64'(idx), 64'(ntx));
        check(done_cycles == 1, "R10", $sformatf("scenario %0d done width", s),
              64'(done_cycles), 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R10", "reset req_ready", 64'(req_ready), 64'd1);
        check(txn_valid == 1'b0, "R9", "reset txn_valid", 64'(txn_valid), 64'd0);
        check(done == 1'b0, "R10", "reset done", 64'(done), 64'd0);

        for (int s = 0; s < NS; s++) begin
            offer(REQ[s]);
            drain(s, FIRST[s], NTX[s], 1'b1);
        end

        // directed: hold under stall, request ignored while busy
        offer(REQ[0]);
        req_addr  = 32'h0000_0300;
        req_len   = 16'd4;
        req_valid = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(req_ready == 1'b0, "R10", "busy req_ready", 64'(req_ready), 64'd0);
        end
        check(txn_valid && txn_addr == 32'h1 && txn_be == 4'hE, "R9", "held first txn",
              {31'h0, txn_valid, txn_addr}, {31'h0, 1'b1, 32'h1});
        req_valid = 1'b0;
        drain(0, FIRST[0], NTX[0], 1'b1);
        @(negedge clk);
        check(txn_valid == 1'b0 && req_ready == 1'b1, "R10", "ignored request not run",
              {62'h0, txn_valid, req_ready}, 64'd1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule